// File: doc/BRIEF.md
# Hot-Plug Detect Interrupt Unit

This unit watches two display hot-plug sense lines and turns changes in panel presence into interrupts for a host. Each sense line is first brought into the local clock domain by a flop chain. Software arms a channel with a detect-enable bit. It then programs a polarity bit that says which sense level counts as an event. The usual practice is to set polarity to 0 while a panel is present and to 1 while none is, so that the next change of state is the one reported. An event latches a sticky per-channel pending bit. That bit stays set until software writes an acknowledge.

Two vertical-blank event pulses and a software interrupt request are collected beside the hot-plug events. Pending display events appear together in a display status register. Enabled ones roll up into a display summary bit in a general status register. That register is write-one-to-clear and also holds the software interrupt bit. A single level-sensitive interrupt line is driven from the general status. All registers sit on a simple 32-bit bus with a write strobe and a read strobe. Read data returns one cycle after the read strobe.

Top module: `hpd_irq_unit`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0.
- R2: While a channel's detect-enable (bit 0 of its control register, word 0 for channel 0 and word 3 for channel 1) is 0, its sense bit reads 0 and it latches no event.
- R3: With detect-enable set, bit 0 of the channel's sense register (word 1 or word 4) reads the synchronised sense input.
- R4: A channel latches a pending event in any cycle where it is enabled and the synchronised sense level equals its polarity bit. The polarity is bit 0 of the interrupt control register (word 2 or word 5), and bit 1 of that register is the interrupt enable. Channel 0 pending shows in bit 2 of the display status register (word 6) and channel 1 pending shows in bit 3.
- R5: A hot-plug pending bit stays set, even after the sense level returns, until a write with bit 2 set to the channel's interrupt control register. Bit 2 always reads 0.
- R6: When an acknowledge and a new hot-plug event occur in the same cycle, the pending bit stays set.
- R7: A pulse on `vblank_evt[i]` sets display status bit i (i = 0, 1), and the bit also reads as bit 0 of word 7+i. Writing 1 to bit 0 of word 7+i clears it, and a same-cycle pulse wins over the clear.
- R8: The general status register (word 11) is write-one-to-clear. Bit 1 is set whenever any enabled display event is pending: a hot-plug event with its interrupt enable set, or a vertical-blank event with its bit set in the mask register (word 9, bit i for display i). Bit 0 is set by a `sw_irq_req` pulse. A new set in the same cycle wins over the clear.
- R9: `irq` is a level that is 1 exactly when general status bit 1 is set, or when general status bit 0 and the software enable (word 10, bit 0) are both set.
- R10: Read data for the word at `reg_addr` appears on `reg_rdata` with `reg_rvalid` high one cycle after `reg_rd`. Unmapped words (12 and up) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| hp_sense_raw | input | 2 | Asynchronous hot-plug sense lines, 1 = panel present |
| vblank_evt | input | 2 | Single-cycle vertical-blank event per display |
| sw_irq_req | input | 1 | Single-cycle software interrupt request |
| irq | output | 1 | Level-sensitive interrupt to the host |

## Verification
The hot-plug path is tried with four patterns. A disconnect is applied under polarity 0 and a connect under polarity 1, which shows that the comparison follows the programmed bit and not a fixed edge. A sense change on a disabled channel separates gating by detect-enable from gating by interrupt enable. An event with its interrupt enable cleared shows that the display status latches while the summary bit and `irq` stay low. Acknowledges are issued both while the trigger condition still holds and after it is removed, which tells set-wins-over-clear apart from a plain clear. Vertical-blank and software requests are given with and without their masks, and with a same-cycle clear. This exercises the separate acknowledge paths of the source bits and of the general status.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
  localparam int unsigned HP_CH     = 2;
  localparam int unsigned VB_CH     = 2;
  localparam int unsigned HP_STRIDE = 3;
  localparam int unsigned W_CTRL    = 0;
  localparam int unsigned W_SENSE   = 1;
  localparam int unsigned W_ICTL    = 2;
  localparam int unsigned W_DSTAT   = 6;
  localparam int unsigned W_VB0     = 7;
  localparam int unsigned W_MASK    = 9;
  localparam int unsigned W_GCTL    = 10;
  localparam int unsigned W_GSTAT   = 11;
  localparam int unsigned B_POL     = 0;
  localparam int unsigned B_IEN     = 1;
  localparam int unsigned B_ACK     = 2;
  localparam int unsigned B_GS_SW   = 0;
  localparam int unsigned B_GS_DISP = 1;
endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = din;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/hpd_channel.sv
module hpd_channel
  import hpd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sense_s,
  input  logic              wr_ctrl,
  input  logic              wr_ictl,
  input  logic [DATA_W-1:0] wdata,
  output logic              det_en,
  output logic              sense_bit,
  output logic              pol,
  output logic              ien,
  output logic              pend
);
  logic det_en_q, det_en_d;
  logic pol_q, pol_d;
  logic ien_q, ien_d;
  logic pend_q, pend_d;
  logic hit, ack;

  assign hit = det_en_q & (sense_s == pol_q);
  assign ack = wr_ictl & wdata[B_ACK];

  always_comb begin
    det_en_d = det_en_q;
    pol_d    = pol_q;
    ien_d    = ien_q;
    if (wr_ctrl) det_en_d = wdata[0];
    if (wr_ictl) begin
      pol_d = wdata[B_POL];
      ien_d = wdata[B_IEN];
    end
    pend_d = hit | (pend_q & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_en_q <= 1'b0;
      pol_q    <= 1'b0;
      ien_q    <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      det_en_q <= det_en_d;
      pol_q    <= pol_d;
      ien_q    <= ien_d;
      pend_q   <= pend_d;
    end
  end

  assign det_en    = det_en_q;
  assign sense_bit = det_en_q & sense_s;
  assign pol       = pol_q;
  assign ien       = ien_q;
  assign pend      = pend_q;
endmodule

// File: rtl/hpd_rollup.sv
module hpd_rollup
  import hpd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VB_CH-1:0]  vb_evt,
  input  logic [VB_CH-1:0]  vb_ack,
  input  logic              wr_mask,
  input  logic              wr_gctl,
  input  logic              wr_gstat,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sw_req,
  input  logic [HP_CH-1:0]  hp_pend,
  input  logic [HP_CH-1:0]  hp_ien,
  output logic [VB_CH-1:0]  vb_pend,
  output logic [VB_CH-1:0]  vb_mask,
  output logic              sw_en,
  output logic              sw_pend,
  output logic              gen_disp,
  output logic              disp_sum,
  output logic              irq
);
  logic [VB_CH-1:0] vb_pend_q, vb_pend_d;
  logic [VB_CH-1:0] mask_q, mask_d;
  logic             sw_en_q, sw_en_d;
  logic             sw_pend_q, sw_pend_d;
  logic             gdisp_q, gdisp_d;

  assign disp_sum = (|(hp_pend & hp_ien)) | (|(vb_pend_q & mask_q));

  always_comb begin
    vb_pend_d = vb_evt | (vb_pend_q & ~vb_ack);
    mask_d    = wr_mask ? wdata[VB_CH-1:0] : mask_q;
    sw_en_d   = wr_gctl ? wdata[0] : sw_en_q;
    sw_pend_d = sw_req | (sw_pend_q & ~(wr_gstat & wdata[B_GS_SW]));
    gdisp_d   = disp_sum | (gdisp_q & ~(wr_gstat & wdata[B_GS_DISP]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vb_pend_q <= '0;
      mask_q    <= '0;
      sw_en_q   <= 1'b0;
      sw_pend_q <= 1'b0;
      gdisp_q   <= 1'b0;
    end else begin
      vb_pend_q <= vb_pend_d;
      mask_q    <= mask_d;
      sw_en_q   <= sw_en_d;
      sw_pend_q <= sw_pend_d;
      gdisp_q   <= gdisp_d;
    end
  end

  assign vb_pend  = vb_pend_q;
  assign vb_mask  = mask_q;
  assign sw_en    = sw_en_q;
  assign sw_pend  = sw_pend_q;
  assign gen_disp = gdisp_q;
  assign irq      = (sw_pend_q & sw_en_q) | gdisp_q;
endmodule

// File: rtl/hpd_irq_unit.sv
module hpd_irq_unit
  import hpd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  input  logic [HP_CH-1:0]  hp_sense_raw,
  input  logic [VB_CH-1:0]  vblank_evt,
  input  logic              sw_irq_req,
  output logic              irq
);
  logic [1:0] rst_ff_q;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff_q <= 2'b00;
    else        rst_ff_q <= {rst_ff_q[0], 1'b1};
  end
  assign rst_n_sync = rst_ff_q[1];

  logic [HP_CH-1:0] sense_s, det_en, sense_bit, pol, ien, hp_pend;
  logic [VB_CH-1:0] vb_pend, vb_mask, vb_ack;
  logic             sw_en, sw_pend, gen_disp, disp_sum;

  hpd_sync #(.W(HP_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_sync), .din(hp_sense_raw), .dout(sense_s)
  );

  for (genvar c = 0; c < HP_CH; c++) begin : g_ch
    localparam int unsigned BASE = c * HP_STRIDE;
    logic wr_ctrl, wr_ictl;
    assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(BASE + W_CTRL));
    assign wr_ictl = reg_wr && (reg_addr == ADDR_W'(BASE + W_ICTL));
    hpd_channel #(.DATA_W(DATA_W)) u_ch (
      .clk(clk), .rst_n(rst_n_sync), .sense_s(sense_s[c]),
      .wr_ctrl(wr_ctrl), .wr_ictl(wr_ictl), .wdata(reg_wdata),
      .det_en(det_en[c]), .sense_bit(sense_bit[c]), .pol(pol[c]),
      .ien(ien[c]), .pend(hp_pend[c])
    );
  end

  for (genvar v = 0; v < VB_CH; v++) begin : g_vback
    assign vb_ack[v] = reg_wr && (reg_addr == ADDR_W'(W_VB0 + v)) && reg_wdata[0];
  end

  hpd_rollup #(.DATA_W(DATA_W)) u_roll (
    .clk(clk), .rst_n(rst_n_sync), .vb_evt(vblank_evt), .vb_ack(vb_ack),
    .wr_mask(reg_wr && (reg_addr == ADDR_W'(W_MASK))),
    .wr_gctl(reg_wr && (reg_addr == ADDR_W'(W_GCTL))),
    .wr_gstat(reg_wr && (reg_addr == ADDR_W'(W_GSTAT))),
    .wdata(reg_wdata), .sw_req(sw_irq_req), .hp_pend(hp_pend), .hp_ien(ien),
    .vb_pend(vb_pend), .vb_mask(vb_mask), .sw_en(sw_en), .sw_pend(sw_pend),
    .gen_disp(gen_disp), .disp_sum(disp_sum), .irq(irq)
  );

  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q;

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < HP_CH; c++) begin
      if (reg_addr == ADDR_W'(c * HP_STRIDE + W_CTRL))  rd_mux[0] = det_en[c];
      if (reg_addr == ADDR_W'(c * HP_STRIDE + W_SENSE)) rd_mux[0] = sense_bit[c];
      if (reg_addr == ADDR_W'(c * HP_STRIDE + W_ICTL)) begin
        rd_mux[B_POL] = pol[c];
        rd_mux[B_IEN] = ien[c];
      end
    end
    for (int v = 0; v < VB_CH; v++) begin
      if (reg_addr == ADDR_W'(W_VB0 + v)) rd_mux[0] = vb_pend[v];
    end
    if (reg_addr == ADDR_W'(W_DSTAT)) rd_mux[VB_CH+HP_CH-1:0] = {hp_pend, vb_pend};
    if (reg_addr == ADDR_W'(W_MASK))  rd_mux[VB_CH-1:0] = vb_mask;
    if (reg_addr == ADDR_W'(W_GCTL))  rd_mux[0] = sw_en;
    if (reg_addr == ADDR_W'(W_GSTAT)) begin
      rd_mux[B_GS_SW]   = sw_pend;
      rd_mux[B_GS_DISP] = gen_disp;
    end
    rdata_d = reg_rd ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= reg_rd;
    end
  end

  assign reg_rdata  = rdata_q;
  assign reg_rvalid = rvalid_q;
endmodule

// File: rtl/hpd_irq_sva.sv
module hpd_irq_sva #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              reg_rvalid,
  input logic              irq,
  input logic [1:0]        det_en,
  input logic [1:0]        hp_pend,
  input logic              disp_sum,
  input logic              gen_disp,
  input logic              sw_pend
);
  // R2: a channel's pending bit can only rise if it was enabled
  a_r2_no_event_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hp_pend[0]) |-> $past(det_en[0]));
  a_r2_no_event_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hp_pend[1]) |-> $past(det_en[1]));

  // R5: pending holds unless acknowledged
  a_r5_sticky_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_pend[0] && !(reg_wr && reg_addr == ADDR_W'(2) && reg_wdata[2])) |=> hp_pend[0]);
  a_r5_sticky_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_pend[1] && !(reg_wr && reg_addr == ADDR_W'(5) && reg_wdata[2])) |=> hp_pend[1]);

  // R8: an enabled display event always reaches the summary bit
  a_r8_summary_latch: assert property (@(posedge clk) disable iff (!rst_n)
    disp_sum |=> gen_disp);

  // R9: no interrupt without a general status source
  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_pend && !gen_disp) |-> !irq);

  // R10: read response timing
  a_r10_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);
endmodule

bind hpd_irq_unit hpd_irq_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
  .clk(clk), .rst_n(rst_n_sync), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid),
  .irq(irq), .det_en(det_en), .hp_pend(hp_pend), .disp_sum(disp_sum),
  .gen_disp(gen_disp), .sw_pend(sw_pend)
);

// File: tb/hpd_irq_unit_tb.sv
module hpd_irq_unit_tb;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0, reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              reg_rvalid;
  logic [1:0]        hp_sense_raw = 2'b00;
  logic [1:0]        vblank_evt = 2'b00;
  logic              sw_irq_req = 1'b0;
  logic              irq;

  int n_vec = 0;
  int n_bad = 0;

  typedef struct {
    int          addr;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sb[$];

  always #5 clk = ~clk;

  hpd_irq_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .hp_sense_raw(hp_sense_raw),
    .vblank_evt(vblank_evt), .sw_irq_req(sw_irq_req), .irq(irq)
  );

  // monitor: pop expected read data as responses appear
  always @(negedge clk) begin
    if (reg_rvalid) begin
      if (sb.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R10 unexpected read response got %h exp none", reg_rdata);
      end else begin
        sb_item_t it;
        it = sb.pop_front();
        n_vec++;
        if (reg_rdata !== it.exp) begin
          n_bad++;
          $display("FAIL %s word %0d got %h exp %h", it.tag, it.addr, reg_rdata, it.exp);
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_exp(input int a, input logic [31:0] e, input string tag);
    sb_item_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    @(negedge clk);
    sb.push_back(it);
    reg_rd = 1'b1; reg_addr = ADDR_W'(a);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    n_vec++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s irq got %b exp %b", tag, irq, e);
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired got hang exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);

    // R1 reset state
    chk_irq(1'b0, "R1");
    for (int a = 0; a < 12; a++) rd_exp(a, 32'h0, "R1");
    rd_exp(15, 32'h0, "R10");

    // R2 sense while channel 0 disabled
    hp_sense_raw[0] = 1'b1;
    wait_cyc(6);
    rd_exp(1, 32'h0, "R2");
    rd_exp(6, 32'h0, "R2");

    // R3 enable channel 0, polarity 0 (connected), interrupt enable
    wr(0, 32'h1);
    wr(2, 32'h2);
    wait_cyc(3);
    rd_exp(1, 32'h1, "R3");
    rd_exp(6, 32'h0, "R4");
    rd_exp(2, 32'h2, "R5");

    // R4 disconnect under polarity 0
    hp_sense_raw[0] = 1'b0;
    wait_cyc(6);
    rd_exp(6, 32'h4, "R4");
    rd_exp(11, 32'h2, "R8");
    chk_irq(1'b1, "R9");

    // R6 acknowledge while condition still true
    wr(2, 32'h6);
    wait_cyc(2);
    rd_exp(6, 32'h4, "R6");

    // R5 flip polarity, then acknowledge
    wr(2, 32'h3);
    wr(2, 32'h7);
    wait_cyc(2);
    rd_exp(6, 32'h0, "R5");
    rd_exp(11, 32'h2, "R8");
    chk_irq(1'b1, "R9");
    wr(11, 32'h2);
    wait_cyc(2);
    rd_exp(11, 32'h0, "R8");
    chk_irq(1'b0, "R9");

    // R4 connect under polarity 1
    hp_sense_raw[0] = 1'b1;
    wait_cyc(6);
    rd_exp(6, 32'h4, "R4");
    wr(2, 32'h2);
    wr(2, 32'h6);
    wait_cyc(2);
    rd_exp(6, 32'h0, "R5");
    wr(11, 32'h2);
    wait_cyc(2);
    chk_irq(1'b0, "R9");

    // R4 channel 1 event with interrupt enable cleared
    wr(3, 32'h1);
    wr(5, 32'h0);
    wait_cyc(6);
    rd_exp(6, 32'h8, "R4");
    rd_exp(11, 32'h0, "R8");
    chk_irq(1'b0, "R9");
    wr(5, 32'h1);
    wr(5, 32'h5);
    wait_cyc(2);
    rd_exp(6, 32'h0, "R5");
    wr(3, 32'h0);
    hp_sense_raw[1] = 1'b1;
    wait_cyc(6);
    rd_exp(4, 32'h0, "R2");
    rd_exp(6, 32'h0, "R2");

    // R7 vertical blank display 0
    @(negedge clk); vblank_evt[0] = 1'b1;
    @(negedge clk); vblank_evt[0] = 1'b0;
    wait_cyc(3);
    rd_exp(6, 32'h1, "R7");
    rd_exp(7, 32'h1, "R7");
    rd_exp(11, 32'h0, "R8");
    chk_irq(1'b0, "R9");
    wr(9, 32'h1);
    wait_cyc(3);
    rd_exp(11, 32'h2, "R8");
    chk_irq(1'b1, "R9");
    wr(7, 32'h1);
    wr(11, 32'h2);
    wait_cyc(2);
    rd_exp(6, 32'h0, "R7");
    rd_exp(11, 32'h0, "R8");
    chk_irq(1'b0, "R9");

    // R7 display 1 pulse with same-cycle clear
    @(negedge clk);
    vblank_evt[1] = 1'b1; reg_wr = 1'b1; reg_addr = ADDR_W'(8); reg_wdata = 32'h1;
    @(negedge clk);
    vblank_evt[1] = 1'b0; reg_wr = 1'b0;
    wait_cyc(2);
    rd_exp(6, 32'h2, "R7");
    wr(8, 32'h1);
    wait_cyc(2);
    rd_exp(8, 32'h0, "R7");

    // R8 / R9 software interrupt
    @(negedge clk); sw_irq_req = 1'b1;
    @(negedge clk); sw_irq_req = 1'b0;
    wait_cyc(2);
    rd_exp(11, 32'h1, "R8");
    chk_irq(1'b0, "R9");
    wr(10, 32'h1);
    wait_cyc(1);
    chk_irq(1'b1, "R9");
    @(negedge clk);
    sw_irq_req = 1'b1; reg_wr = 1'b1; reg_addr = ADDR_W'(11); reg_wdata = 32'h1;
    @(negedge clk);
    sw_irq_req = 1'b0; reg_wr = 1'b0;
    wait_cyc(2);
    rd_exp(11, 32'h1, "R8");
    wr(11, 32'h1);
    wait_cyc(2);
    rd_exp(11, 32'h0, "R8");
    chk_irq(1'b0, "R9");

    wait_cyc(4);
    if (sb.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL R10 missing read responses got %0d left exp 0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule